// File: doc/BRIEF.md
# Ethernet Start-of-Frame Timestamp Pulse Generator

This block sits on the transmit and receive data paths between an Ethernet PHY and its MAC. It watches each path for the start-of-frame delimiter and produces a one-cycle start-of-packet pulse that a precision time protocol (IEEE 1588) timestamp unit can latch. Each direction has its own delay counter, so its pulse can be moved later by a chosen number of clock cycles. This lets the pulse line up with the moment the frame reaches the line side. Each direction keeps two delay settings, one for byte-wide (gigabit) operation and one for nibble-wide (10/100) operation. The current speed mode picks which one applies.

In byte mode, the delimiter is the byte 0xD5 seen while the path's valid signal is high. In nibble mode, it is the nibble 0x5 followed in the next cycle by the nibble 0xD, both on data bits [3:0], with valid held high across both cycles. A per-direction pin-select field steers each pulse to one of several output pins, or to none. Both path inputs and all outputs share one interface clock.

Top module: `sofTimestampPulser`

## Requirements
- R1: With `gigMode`=1, a path detects a start of packet in any cycle where its valid input is high and its data byte equals 0xD5.
- R2: With `gigMode`=0, a path detects a start of packet in a cycle where valid is high, data[3:0] equals 0xD, and the previous cycle had valid high with data[3:0] equal to 0x5.
- R3: With a selected delay of 0, the pulse is driven in the same cycle in which the delimiter is on the inputs.
- R4: With a selected delay of D > 0, the pulse is driven exactly D cycles after the delimiter cycle, and every pulse is exactly one cycle wide.
- R5: Each direction uses its own delay pair. `gigMode`=1 selects the `*DlyGig` value and `gigMode`=0 selects the `*DlyMii` value. The unselected value has no effect.
- R6: A delimiter that arrives while that path's delayed pulse is still pending is dropped. This includes a delimiter in the cycle in which the pulse is issued and a delimiter in the cycle right after it. A dropped delimiter adds no pulse.
- R7: After a detection, the path's valid input must go low for at least one cycle before the path can detect again. Further delimiters inside the same frame produce no pulse.
- R8: A pin-select value s in 1..NUM_PINS routes that direction's pulse to `sopPins[s-1]`. The value 0, or any value above NUM_PINS, routes it nowhere. When both directions select the same pin, the pin is the OR of the two pulses.
- R9: While `rstN` is low and after it is released, `sopPins` is all zero, and any pulse that was pending before reset is discarded.
- R10: In nibble mode, a 0xD nibble with no 0x5 nibble before it, or with a low-valid cycle between the 0x5 and the 0xD, is not a delimiter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock shared by both paths |
| rstN | input | 1 | Asynchronous active-low reset |
| gigMode | input | 1 | 1: byte-wide data and gigabit delays; 0: nibble data and 10/100 delays |
| txEn | input | 1 | Transmit data valid |
| txData | input | 8 | Transmit data (bits [3:0] used in nibble mode) |
| rxDv | input | 1 | Receive data valid |
| rxData | input | 8 | Receive data (bits [3:0] used in nibble mode) |
| txDlyGig | input | DLY_W | Transmit pulse delay in cycles, gigabit mode |
| txDlyMii | input | DLY_W | Transmit pulse delay in cycles, nibble mode |
| rxDlyGig | input | DLY_W | Receive pulse delay in cycles, gigabit mode |
| rxDlyMii | input | DLY_W | Receive pulse delay in cycles, nibble mode |
| txPinSel | input | SEL_W | Output pin for the transmit pulse (0 = none) |
| rxPinSel | input | SEL_W | Output pin for the receive pulse (0 = none) |
| sopPins | output | NUM_PINS | Start-of-packet pulse outputs |

## Verification
The bench uses the default parameters: NUM_PINS=4, which gives a 3-bit pin select, and DLY_W=8. With a 3-bit select, the unused values 5 to 7 can be driven to confirm that they route nowhere. With DLY_W=8, the bench can run the full delay range, from the zero-delay same-cycle case to the 255-cycle maximum. Short delays also let the bench place a second delimiter exactly on the issue cycle and on the cycle after it.

// File: rtl/sofPkg.sv
package sofPkg;

  localparam logic [7:0] SFD_BYTE = 8'hD5;
  localparam logic [3:0] NIB_PRE  = 4'h5;
  localparam logic [3:0] NIB_SFD  = 4'hD;

  // Strobes from a path's control to its delay datapath
  typedef struct packed {
    logic load;  // start a new delay window
    logic step;  // count the pending window down by one
  } dpStrobe_t;

endpackage

// File: rtl/sofDelayDp.sv
module sofDelayDp
  import sofPkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [DLY_W-1:0] loadVal,
  output logic             busy,
  output logic             lastTick
);

  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.load) begin
      cnt <= loadVal;
    end else if (strb.step) begin
      cnt <= cnt - DLY_W'(1);
    end
  end

  assign busy     = (cnt != '0);
  assign lastTick = (cnt == DLY_W'(1));

  // R4
  load_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (busy && cnt == $past(loadVal)));

  // R4
  count_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.load) |=> (cnt == $past(cnt) - DLY_W'(1)));

endmodule

// File: rtl/sofPathCtrl.sv
module sofPathCtrl
  import sofPkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             gigMode,
  input  logic             valid,
  input  logic [7:0]       data,
  input  logic [DLY_W-1:0] dlyGig,
  input  logic [DLY_W-1:0] dlyMii,
  input  logic             dpBusy,
  input  logic             dpLast,
  output dpStrobe_t        strb,
  output logic [DLY_W-1:0] loadVal,
  output logic             pulse
);

  logic             armed;
  logic             prevPre;
  logic             firedQ;
  logic             byteHit;
  logic             nibHit;
  logic             hit;
  logic             accept;
  logic [DLY_W-1:0] dlySel;

  assign dlySel  = gigMode ? dlyGig : dlyMii;
  assign byteHit = (data == SFD_BYTE);
  assign nibHit  = (data[3:0] == NIB_SFD) && prevPre;
  assign hit     = valid && armed && (gigMode ? byteHit : nibHit);
  assign accept  = hit && !dpBusy && !firedQ;

  assign pulse     = (accept && dlySel == '0) || dpLast;
  assign strb.load = accept && (dlySel != '0);
  assign strb.step = dpBusy;
  assign loadVal   = dlySel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b0;
      prevPre <= 1'b0;
      firedQ  <= 1'b0;
    end else begin
      if (!valid)   armed <= 1'b1;
      else if (hit) armed <= 1'b0;
      prevPre <= valid && (data[3:0] == NIB_PRE);
      firedQ  <= pulse;
    end
  end

  // R4
  one_wide_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulse |=> !pulse);

  // R6
  pend_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    dpBusy |-> !strb.load);

  // R7
  once_per_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (valid && hit) |=> (valid |-> !hit));

endmodule

// File: rtl/sofTimestampPulser.sv
module sofTimestampPulser #(
  parameter  int DLY_W    = 8,
  parameter  int NUM_PINS = 4,
  localparam int SEL_W    = $clog2(NUM_PINS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                gigMode,
  input  logic                txEn,
  input  logic [7:0]          txData,
  input  logic                rxDv,
  input  logic [7:0]          rxData,
  input  logic [DLY_W-1:0]    txDlyGig,
  input  logic [DLY_W-1:0]    txDlyMii,
  input  logic [DLY_W-1:0]    rxDlyGig,
  input  logic [DLY_W-1:0]    rxDlyMii,
  input  logic [SEL_W-1:0]    txPinSel,
  input  logic [SEL_W-1:0]    rxPinSel,
  output logic [NUM_PINS-1:0] sopPins
);

  localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(NUM_PINS);

  logic txPulse;
  logic rxPulse;

  sofPkg::dpStrobe_t txStrb, rxStrb;
  logic [DLY_W-1:0]  txLoad, rxLoad;
  logic              txBusy, txLast, rxBusy, rxLast;

  sofPathCtrl #(.DLY_W(DLY_W)) txCtrl_i (
    .clk(clk), .rstN(rstN), .gigMode(gigMode), .valid(txEn), .data(txData),
    .dlyGig(txDlyGig), .dlyMii(txDlyMii), .dpBusy(txBusy), .dpLast(txLast),
    .strb(txStrb), .loadVal(txLoad), .pulse(txPulse));

  sofDelayDp #(.DLY_W(DLY_W)) txDp_i (
    .clk(clk), .rstN(rstN), .strb(txStrb), .loadVal(txLoad),
    .busy(txBusy), .lastTick(txLast));

  sofPathCtrl #(.DLY_W(DLY_W)) rxCtrl_i (
    .clk(clk), .rstN(rstN), .gigMode(gigMode), .valid(rxDv), .data(rxData),
    .dlyGig(rxDlyGig), .dlyMii(rxDlyMii), .dpBusy(rxBusy), .dpLast(rxLast),
    .strb(rxStrb), .loadVal(rxLoad), .pulse(rxPulse));

  sofDelayDp #(.DLY_W(DLY_W)) rxDp_i (
    .clk(clk), .rstN(rstN), .strb(rxStrb), .loadVal(rxLoad),
    .busy(rxBusy), .lastTick(rxLast));

  for (genvar p = 0; p < NUM_PINS; p++) begin : gPin
    assign sopPins[p] = (txPulse && txPinSel == SEL_W'(p + 1))
                     || (rxPulse && rxPinSel == SEL_W'(p + 1));
  end

  // R8
  unrouted_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((txPinSel == '0 || txPinSel > MAX_SEL) && (rxPinSel == '0 || rxPinSel > MAX_SEL))
      |-> (sopPins == '0));

  // R8
  pin_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(sopPins) <= 2);

  // R9
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reset_quiet_chk: assert (sopPins == '0);
    end
  end

endmodule

// File: tb/sofTimestampPulser_tb.sv
module sofTimestampPulser_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       gigMode = 1'b1;
  logic       txEn = 1'b0, rxDv = 1'b0;
  logic [7:0] txData = '0, rxData = '0;
  logic [7:0] txDlyGig = '0, txDlyMii = '0, rxDlyGig = '0, rxDlyMii = '0;
  logic [2:0] txPinSel = 3'd1, rxPinSel = 3'd2;
  logic [3:0] sopPins;

  int nRun = 0, nFail = 0;
  int tNow, tFirst, tCnt, tStray, tBit;

  always #2 clk = ~clk;

  sofTimestampPulser dut_i (
    .clk(clk), .rstN(rstN), .gigMode(gigMode),
    .txEn(txEn), .txData(txData), .rxDv(rxDv), .rxData(rxData),
    .txDlyGig(txDlyGig), .txDlyMii(txDlyMii), .rxDlyGig(rxDlyGig), .rxDlyMii(rxDlyMii),
    .txPinSel(txPinSel), .rxPinSel(rxPinSel), .sopPins(sopPins));

  task automatic chk(input bit ok, input string tag, input string act, input string exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  // one cycle: inputs change after the edge, outputs sampled before the next
  task automatic cyc(input logic tv, input logic [7:0] td, input logic rv, input logic [7:0] rd,
                     output logic [3:0] p);
    @(posedge clk);
    #1;
    txEn = tv; txData = td; rxDv = rv; rxData = rd;
    #1;
    p = sopPins;
  endtask

  task automatic clrTally(input int bitIdx);
    tFirst = -1; tCnt = 0; tStray = 0; tBit = bitIdx;
  endtask

  task automatic pathStep(input bit isRx, input logic v, input logic [7:0] d);
    logic [3:0] p;
    if (isRx) cyc(1'b0, 8'h00, v, d, p);
    else      cyc(v, d, 1'b0, 8'h00, p);
    for (int i = 0; i < 4; i++) begin
      if (p[i]) begin
        if (i == tBit && tNow >= 0) begin
          if (tFirst < 0) tFirst = tNow;
          tCnt++;
        end else begin
          tStray++;
        end
      end
    end
    tNow++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) pathStep(1'b0, 1'b0, 8'h00);
  endtask

  task automatic setDly(input bit isRx, input bit gig, input int dly);
    logic [7:0] sel, other;
    sel = 8'(dly); other = 8'(dly + 7);
    gigMode = gig;
    if (isRx) begin
      rxDlyGig = gig ? sel : other; rxDlyMii = gig ? other : sel;
    end else begin
      txDlyGig = gig ? sel : other; txDlyMii = gig ? other : sel;
    end
  endtask

  // full frame; pinIdx < 0 means the pulse must appear on no pin
  task automatic frameCheck(input bit isRx, input bit gig, input int dly, input int pinIdx,
                            input string tag);
    setDly(isRx, gig, dly);
    clrTally(pinIdx);
    tNow = -10;
    idle(2);
    for (int i = 0; i < 4; i++) pathStep(isRx, 1'b1, gig ? 8'h55 : 8'h05);
    tNow = 0;
    pathStep(isRx, 1'b1, gig ? 8'hD5 : 8'h0D);
    for (int i = 0; i < dly + 4; i++) pathStep(isRx, 1'b1, 8'h00);
    idle(2);
    if (pinIdx >= 0)
      chk(tFirst == dly && tCnt == 1 && tStray == 0, tag,
          $sformatf("first=%0d cnt=%0d stray=%0d", tFirst, tCnt, tStray),
          $sformatf("first=%0d cnt=1 stray=0", dly));
    else
      chk(tCnt == 0 && tStray == 0, tag,
          $sformatf("cnt=%0d stray=%0d", tCnt, tStray), "no pulse on any pin");
  endtask

  task automatic testReset();
    logic [3:0] p;
    cyc(1'b0, 8'h00, 1'b0, 8'h00, p);
    chk(p == 4'b0, "R9 reset", $sformatf("%b", p), "0000");
    // pending pulse killed by reset
    setDly(1'b1, 1'b1, 10);
    clrTally(1); tNow = -10;
    idle(2);
    pathStep(1'b1, 1'b1, 8'h55);
    pathStep(1'b1, 1'b1, 8'hD5);
    @(posedge clk); #1 rstN = 1'b0; rxDv = 1'b0;
    tNow = 0;
    @(posedge clk); #1 rstN = 1'b1;
    idle(16);
    chk(tCnt == 0 && tStray == 0, "R9 pending cleared",
        $sformatf("cnt=%0d stray=%0d", tCnt, tStray), "no pulse");
  endtask

  task automatic testPending();
    // R6: delimiter during pending window dropped
    setDly(1'b1, 1'b1, 6);
    clrTally(1); tNow = -10;
    idle(2);
    pathStep(1'b1, 1'b1, 8'h55);
    tNow = 0;
    pathStep(1'b1, 1'b1, 8'hD5);
    pathStep(1'b1, 1'b0, 8'h00);
    pathStep(1'b1, 1'b1, 8'h55);
    pathStep(1'b1, 1'b1, 8'hD5);
    for (int i = 0; i < 8; i++) pathStep(1'b1, 1'b1, 8'h00);
    idle(2);
    chk(tFirst == 6 && tCnt == 1 && tStray == 0, "R6 drop while pending",
        $sformatf("first=%0d cnt=%0d", tFirst, tCnt), "first=6 cnt=1");
    // R6: delimiter in the cycle right after the pulse dropped
    setDly(1'b1, 1'b1, 4);
    clrTally(1); tNow = -10;
    idle(2);
    pathStep(1'b1, 1'b1, 8'h55);
    tNow = 0;
    pathStep(1'b1, 1'b1, 8'hD5);
    for (int i = 0; i < 4; i++) pathStep(1'b1, 1'b0, 8'h00);
    pathStep(1'b1, 1'b1, 8'hD5);
    for (int i = 0; i < 6; i++) pathStep(1'b1, 1'b1, 8'h00);
    idle(2);
    chk(tFirst == 4 && tCnt == 1 && tStray == 0, "R6 drop after pulse",
        $sformatf("first=%0d cnt=%0d", tFirst, tCnt), "first=4 cnt=1");
  endtask

  task automatic testOncePerFrame();
    setDly(1'b0, 1'b1, 0);
    clrTally(0); tNow = -10;
    idle(2);
    pathStep(1'b0, 1'b1, 8'h55);
    tNow = 0;
    pathStep(1'b0, 1'b1, 8'hD5);
    pathStep(1'b0, 1'b1, 8'hD5);
    pathStep(1'b0, 1'b1, 8'h55);
    pathStep(1'b0, 1'b1, 8'hD5);
    pathStep(1'b0, 1'b1, 8'h00);
    idle(2);
    chk(tFirst == 0 && tCnt == 1 && tStray == 0, "R7 one pulse per frame",
        $sformatf("first=%0d cnt=%0d", tFirst, tCnt), "first=0 cnt=1");
  endtask

  task automatic testNibbleBad();
    setDly(1'b0, 1'b0, 0);
    clrTally(0); tNow = -10;
    idle(2);
    pathStep(1'b0, 1'b1, 8'h0D);
    pathStep(1'b0, 1'b1, 8'h05);
    pathStep(1'b0, 1'b0, 8'h00);
    pathStep(1'b0, 1'b1, 8'h0D);
    pathStep(1'b0, 1'b1, 8'h05);
    pathStep(1'b0, 1'b1, 8'h06);
    pathStep(1'b0, 1'b1, 8'h0D);
    pathStep(1'b0, 1'b0, 8'h00);
    chk(tStray == 0, "R10 broken nibble pairs", $sformatf("pulses=%0d", tStray), "0");
    pathStep(1'b0, 1'b1, 8'h05);
    tNow = 0;
    pathStep(1'b0, 1'b1, 8'h0D);
    pathStep(1'b0, 1'b1, 8'h00);
    idle(2);
    chk(tFirst == 0 && tCnt == 1 && tStray == 0, "R10 good pair afterwards",
        $sformatf("first=%0d cnt=%0d", tFirst, tCnt), "first=0 cnt=1");
  endtask

  task automatic testShared();
    logic [3:0] p;
    txPinSel = 3'd4; rxPinSel = 3'd4;
    setDly(1'b0, 1'b1, 0); setDly(1'b1, 1'b1, 0);
    cyc(1'b0, 8'h00, 1'b0, 8'h00, p);
    cyc(1'b0, 8'h00, 1'b0, 8'h00, p);
    for (int i = 0; i < 3; i++) cyc(1'b1, 8'h55, 1'b1, 8'h55, p);
    cyc(1'b1, 8'hD5, 1'b1, 8'hD5, p);
    chk(p == 4'b1000, "R8 shared pin", $sformatf("%b", p), "1000");
    cyc(1'b1, 8'h00, 1'b1, 8'h00, p);
    cyc(1'b0, 8'h00, 1'b0, 8'h00, p);
    txPinSel = 3'd1; rxPinSel = 3'd2;
  endtask

  initial begin
    #(200000 * 4);
    nRun++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    frameCheck(1'b0, 1'b1, 0,   0, "R1 R3 tx byte delay 0");
    frameCheck(1'b1, 1'b1, 3,   1, "R1 R4 R5 rx byte delay 3");
    frameCheck(1'b0, 1'b1, 255, 0, "R4 tx byte delay 255");
    frameCheck(1'b1, 1'b0, 2,   1, "R2 R5 rx nibble delay 2");
    frameCheck(1'b0, 1'b0, 0,   0, "R2 R3 tx nibble delay 0");
    frameCheck(1'b1, 1'b0, 1,   1, "R4 rx nibble delay 1");
    testPending();
    testOncePerFrame();
    testNibbleBad();
    txPinSel = 3'd3;
    frameCheck(1'b0, 1'b1, 1, 2, "R8 tx to pin 2");
    txPinSel = 3'd0;
    frameCheck(1'b0, 1'b1, 0, -1, "R8 select none");
    txPinSel = 3'd5;
    frameCheck(1'b0, 1'b1, 0, -1, "R8 select out of range");
    txPinSel = 3'd1;
    testShared();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule